// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is an SPI master that sits on a simple 32-bit word-access register bus. Software loads bytes into a transmit queue. The controller shifts each byte out on the serial clock and data-out lines, and it captures one byte from the data-in line for every byte it sends. Captured bytes collect in a receive queue, and software reads them back one at a time. Each slave-select register bit drives its own active-low chip-select line.

An inhibit bit in the control register lets software queue a burst of bytes and then release them all at once. Two self-clearing control bits empty either queue. Writing a key value to a reset register puts the whole block back to its power-up state. Interrupt aggregation is handled elsewhere, so the block reports a receive overrun only as a one-cycle event pulse. Its status register shows the queue levels.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the block reads as follows: status reads 0x5, control reads 0, slave select reads 0xFFFFFFFF, every cs_n line is high, and both occupancy registers read 0. The register byte addresses are:
  - 0x40: software reset
  - 0x60: control
  - 0x64: status
  - 0x68: transmit data
  - 0x6C: receive data
  - 0x70: slave select
  - 0x74: transmit occupancy
  - 0x78: receive occupancy
- R2: A write of exactly 0x0000000A to address 0x40 returns the registers, both queues and the serial engine to the reset state. A write of any other value there changes nothing.
- R3: Writing control bit 5 empties the transmit queue, and writing control bit 6 empties the receive queue. Neither bit is stored, so both read back as 0. The other written control bits are kept.
- R4: While control bit 8 is 1, written bytes wait in the transmit queue and the serial lines stay idle. When bit 8 is written to 0, every queued byte is sent, in order.
- R5: The status register holds four bits: bit 0 is receive empty, bit 1 is receive full, bit 2 is transmit empty and bit 3 is transmit full. All other status bits read 0, and writes to the status register have no effect.
- R6: Line cs_n[i] follows slave-select bit i, so the line is low exactly when that bit is 0.
- R7: Each byte sent stores one captured byte in the receive queue. If the receive queue is already full when that byte completes, the byte is dropped and evt_rx_overrun pulses high for one cycle.
- R8: Reading address 0x6C while the receive queue is empty returns 0xDEADBEEF and leaves both queues unchanged.
- R9: Each queue holds FIFO_DEPTH bytes. A transmit-data write uses only bits 7:0, and a write to a full transmit queue is dropped. Each occupancy register reads the entry count minus one, or 0 when its queue is empty.
- R10: The serial clock idles low and runs at the system clock divided by CLK_DIV. Data-out changes after the falling edge and data-in is sampled on the rising edge, with the most significant bit first. One byte finishes before the next one leaves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| evt_rx_overrun | output | 1 | One-cycle pulse when a received byte is dropped |

## Verification
The bench builds the block with FIFO_DEPTH = 8, CLK_DIV = 4 and NUM_CS = 2. With a depth of 8, the full flags, the dropped ninth transmit write and the receive overrun are all reached in a few hundred cycles. A divisor of 4 makes the serial clock period measurable against the system clock. Two chip selects show that each line follows its own bit. The bench slave returns the inverse of each data-out bit, and a monitor captures data-out on rising edges, so any error in bit order, sampling edge or queue ordering shows up as a wrong byte.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam logic [7:0]  OFS_SRST  = 8'h40;
    localparam logic [7:0]  OFS_CTRL  = 8'h60;
    localparam logic [7:0]  OFS_STAT  = 8'h64;
    localparam logic [7:0]  OFS_TXD   = 8'h68;
    localparam logic [7:0]  OFS_RXD   = 8'h6C;
    localparam logic [7:0]  OFS_SSEL  = 8'h70;
    localparam logic [7:0]  OFS_TXOCC = 8'h74;
    localparam logic [7:0]  OFS_RXOCC = 8'h78;
    localparam logic [31:0] SRST_KEY  = 32'h0000_000A;
    localparam logic [31:0] POISON    = 32'hDEAD_BEEF;
    localparam int CTRL_TXCLR = 5;
    localparam int CTRL_RXCLR = 6;
    localparam int CTRL_INH   = 8;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [7:0]                 wdata,
    input  logic                       pop,
    output logic [7:0]                 rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [7:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic          done;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    tx_sh;
        logic [7:0]    rx_sh;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.tx_sh = tx_byte;
                st_d.div   = '0;
                st_d.bitn  = '0;
                st_d.sclk  = 1'b0;
            end
        end else if (st_q.div == DW'(HALF - 1)) begin
            st_d.div  = '0;
            st_d.sclk = !st_q.sclk;
            if (!st_q.sclk) begin
                st_d.rx_sh = {st_q.rx_sh[6:0], miso};
            end else if (st_q.bitn == 3'd7) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
                st_d.bitn  = st_q.bitn + 1'b1;
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rx_byte = st_q.rx_sh;
    assign sclk    = st_q.sclk;
    assign mosi    = st_q.tx_sh[7];
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int NUM_CS     = 1,
    parameter int FIFO_DEPTH = 256,
    parameter int CLK_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              evt_rx_overrun
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [31:0] CTRL_SELFCLR = (32'd1 << CTRL_TXCLR) | (32'd1 << CTRL_RXCLR);

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] ssel;
    } regs_t;

    regs_t r_d, r_q;

    logic wr, rd, soft_rst, ctrl_wr, tx_clr, rx_clr;
    logic tx_push, tx_pop, rx_push, rx_pop, start, inhibit;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic sh_busy, sh_done;
    logic [7:0] tx_head, rx_head, sh_rx;
    logic [CW-1:0] tx_cnt, rx_cnt;

    function automatic logic [31:0] occ(input logic [CW-1:0] c);
        return (c == '0) ? 32'd0 : 32'(c) - 32'd1;
    endfunction

    assign wr       = bus_sel && bus_wr;
    assign rd       = bus_sel && !bus_wr;
    assign soft_rst = wr && (bus_addr == OFS_SRST) && (bus_wdata == SRST_KEY);
    assign ctrl_wr  = wr && (bus_addr == OFS_CTRL);
    assign tx_clr   = soft_rst || (ctrl_wr && bus_wdata[CTRL_TXCLR]);
    assign rx_clr   = soft_rst || (ctrl_wr && bus_wdata[CTRL_RXCLR]);
    assign inhibit  = r_q.ctrl[CTRL_INH];
    assign tx_push  = wr && (bus_addr == OFS_TXD);
    assign start    = !sh_busy && !tx_empty && !inhibit && !tx_clr;
    assign tx_pop   = start;
    assign rx_push  = sh_done && !rx_full;
    assign rx_pop   = rd && (bus_addr == OFS_RXD) && !rx_empty;
    assign evt_rx_overrun = sh_done && rx_full && !rx_clr;

    always_comb begin
        r_d = r_q;
        if (soft_rst) begin
            r_d.ctrl = '0;
            r_d.ssel = '1;
        end else if (ctrl_wr) begin
            r_d.ctrl = bus_wdata & ~CTRL_SELFCLR;
        end else if (wr && bus_addr == OFS_SSEL) begin
            r_d.ssel = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= '0;
            r_q.ssel <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = r_q.ctrl;
            OFS_STAT:  bus_rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:   bus_rdata = rx_empty ? POISON : {24'd0, rx_head};
            OFS_SSEL:  bus_rdata = r_q.ssel;
            OFS_TXOCC: bus_rdata = occ(tx_cnt);
            OFS_RXOCC: bus_rdata = occ(rx_cnt);
            default:   bus_rdata = 32'd0;
        endcase
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = r_q.ssel[i];
    end

    byte_fifo #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(bus_wdata[7:0]), .pop(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .wdata(sh_rx), .pop(rx_pop),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .start(start), .tx_byte(tx_head),
        .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk
    import spi_host_pkg::*;
#(
    parameter int NUM_CS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic              sh_busy,
    input logic              inhibit
);
    a_r6_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_SSEL)
        |=> (cs_n == $past(bus_wdata[NUM_CS-1:0])));

    a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_SRST && bus_wdata == SRST_KEY)
        |=> (tx_empty && rx_empty && (&cs_n) && !inhibit));

    a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_RXCLR])
        |=> rx_empty);

    a_r8_poison: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_RXD && rx_empty)
        |-> (bus_rdata == POISON));

    a_r4_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !sh_busy) |=> !sh_busy);

    a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> !sclk);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 2;
    localparam int DEP = 8;
    localparam int DIV = 4;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic sclk, mosi, miso;
    logic [NCS-1:0] cs_n;
    logic evt_rx_overrun;

    int n_chk = 0, n_fail = 0, n_ovr = 0;
    int cyc = 0, last_rise = 0, sclk_per = 0;
    logic [7:0] mon = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso = ~mosi;

    spi_host_ctrl #(.NUM_CS(NCS), .FIFO_DEPTH(DEP), .CLK_DIV(DIV)) dut (.*);

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && evt_rx_overrun) n_ovr = n_ovr + 1;
    end
    always @(posedge sclk) begin
        mon = {mon[6:0], mosi};
        sclk_per = cyc - last_rise;
        last_rise = cyc;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset_state();
        rd(8'h64, rv); chk("R1 status", rv, 32'h5);
        rd(8'h60, rv); chk("R1 ctrl", rv, 32'h0);
        rd(8'h70, rv); chk("R1 ssel", rv, 32'hFFFF_FFFF);
        chk("R1 cs_n", 32'(cs_n), 32'h3);
        rd(8'h74, rv); chk("R1 txocc", rv, 32'h0);
        rd(8'h78, rv); chk("R1 rxocc", rv, 32'h0);
    endtask

    task automatic t_poison();
        rd(8'h6C, rv); chk("R8 poison", rv, 32'hDEAD_BEEF);
        rd(8'h64, rv); chk("R8 status unchanged", rv, 32'h5);
        rd(8'h78, rv); chk("R8 rxocc unchanged", rv, 32'h0);
    endtask

    task automatic t_single();
        wr(8'h70, 32'h2);
        @(negedge clk); chk("R6 cs_n", 32'(cs_n), 32'h2);
        wr(8'h68, 32'h1A5);
        idle(60);
        chk("R10 msb first", 32'(mon), 32'hA5);
        chk("R10 sclk period", sclk_per, DIV);
        chk("R10 sclk idle", 32'(sclk), 32'h0);
        rd(8'h78, rv); chk("R9 rxocc one", rv, 32'h0);
        rd(8'h64, rv); chk("R5 status one rx", rv, 32'h4);
        rd(8'h6C, rv); chk("R7 rx byte", rv, 32'h5A);
        rd(8'h64, rv); chk("R5 status empty", rv, 32'h5);
    endtask

    task automatic t_inhibit();
        wr(8'h60, 32'h100);
        wr(8'h68, 32'h11); wr(8'h68, 32'h22); wr(8'h68, 32'h33);
        idle(100);
        rd(8'h64, rv); chk("R4 held status", rv, 32'h1);
        rd(8'h74, rv); chk("R9 txocc three", rv, 32'h2);
        wr(8'h60, 32'h0);
        idle(150);
        rd(8'h78, rv); chk("R4 drained rxocc", rv, 32'h2);
        rd(8'h6C, rv); chk("R4 order 1", rv, 32'hEE);
        rd(8'h6C, rv); chk("R4 order 2", rv, 32'hDD);
        rd(8'h6C, rv); chk("R4 order 3", rv, 32'hCC);
        rd(8'h64, rv); chk("R5 status after drain", rv, 32'h5);
    endtask

    task automatic t_tx_full();
        wr(8'h60, 32'h100);
        for (int i = 0; i < DEP; i++) wr(8'h68, 32'(i));
        rd(8'h64, rv); chk("R5 tx full", rv, 32'h9);
        rd(8'h74, rv); chk("R9 txocc full", rv, 32'(DEP - 1));
        wr(8'h68, 32'hFF);
        rd(8'h74, rv); chk("R9 drop extra", rv, 32'(DEP - 1));
        wr(8'h60, 32'h120);
        rd(8'h64, rv); chk("R3 tx flushed", rv, 32'h5);
        rd(8'h60, rv); chk("R3 selfclear", rv, 32'h100);
        rd(8'h74, rv); chk("R3 txocc zero", rv, 32'h0);
        wr(8'h60, 32'h0);
    endtask

    task automatic t_overrun();
        int base;
        wr(8'h60, 32'h100);
        for (int i = 0; i < DEP; i++) wr(8'h68, 32'h40 + 32'(i));
        wr(8'h60, 32'h0);
        idle(DEP * 40 + 20);
        rd(8'h64, rv); chk("R5 rx full", rv, 32'h6);
        rd(8'h78, rv); chk("R9 rxocc full", rv, 32'(DEP - 1));
        chk("R7 no early overrun", n_ovr, 0);
        base = n_ovr;
        wr(8'h68, 32'h77);
        idle(60);
        chk("R7 overrun pulse", n_ovr - base, 1);
        rd(8'h78, rv); chk("R7 rxocc kept", rv, 32'(DEP - 1));
        rd(8'h6C, rv); chk("R7 oldest kept", rv, 32'hBF);
        wr(8'h60, 32'h40);
        rd(8'h64, rv); chk("R3 rx flushed", rv, 32'h5);
    endtask

    task automatic t_status_write();
        wr(8'h64, 32'hF);
        rd(8'h64, rv); chk("R5 status write ignored", rv, 32'h5);
    endtask

    task automatic t_soft_reset();
        wr(8'h70, 32'h0);
        @(negedge clk); chk("R6 both low", 32'(cs_n), 32'h0);
        wr(8'h60, 32'h100);
        wr(8'h68, 32'h5C);
        wr(8'h40, 32'h5);
        rd(8'h70, rv); chk("R2 bad key ssel", rv, 32'h0);
        rd(8'h60, rv); chk("R2 bad key ctrl", rv, 32'h100);
        rd(8'h64, rv); chk("R2 bad key status", rv, 32'h1);
        wr(8'h40, 32'hA);
        rd(8'h70, rv); chk("R2 ssel reset", rv, 32'hFFFF_FFFF);
        chk("R2 cs_n reset", 32'(cs_n), 32'h3);
        rd(8'h60, rv); chk("R2 ctrl reset", rv, 32'h0);
        rd(8'h64, rv); chk("R2 status reset", rv, 32'h5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset_state();
        t_poison();
        t_single();
        t_inhibit();
        t_tx_full();
        t_overrun();
        t_status_write();
        t_soft_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule